// File: doc/BRIEF.md
# Processor System Bus Request Controller

This block sits on the processor side of a multiplexed system bus that carries addresses and data over one 64-bit path, with a 9-bit command path beside it. A core-side port hands it one read or write request at a time. The block puts the address and an address-type command on the bus and raises its valid-out strobe in that same cycle. It then waits on the matching ready line from the external agent.

A write completes with a single data cycle that the block drives itself. For a read, the block stops driving, pulses release, and lets the agent drive the response word. The returned word goes back to the core one cycle after it is accepted. When the agent raises external-request while the block is idle, the block pulses release and stays off both buses until that request drops. Bus ownership is shown with explicit output-enable pins, so the block has no tristate ports. Every handshake line on the bus is active low.

Top module: `sbrc_req_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `rsp_valid` is 0, `valid_out_n` and `release_n` are 1, and both output enables are 1.
- R2: Only one request is in flight. `req_ready` is 0 from the cycle after a request is accepted until the cycle in which `rsp_valid` is 1.
- R3: In the address cycle, `valid_out_n` is 0 and both enables are 1. `bus_ad_o` holds the request address zero-extended to 64 bits, with the low three bits as the byte address. `bus_cmd_o` is an address command.
- R4: While the ready line that matches the request type is 1 (not ready), the block keeps `valid_out_n` at 0 and holds the address and command unchanged.
- R5: For a read, once `rd_rdy_n` is 0 at a clock edge during the address cycle, the next cycle has both enables at 0 and `release_n` at 0 for exactly that one cycle. The enables stay 0 until the response is taken.
- R6: The response word is taken on the first edge after release at which `valid_in_n` is 0 and `bus_cmd_i` is 9'h180 (data, last word). In the next cycle `rsp_valid` is 1, `rsp_rdata` holds the word and both enables are 1. A `valid_in_n` of 0 with any other command value is ignored.
- R7: For a write, once `wr_rdy_n` is 0 at an edge during the address cycle, the next cycle drives `bus_ad_o` with the write data, `bus_cmd_o` with 9'h180 and `valid_out_n` at 0. In the cycle after that, `rsp_valid` is 1 and `valid_out_n` is 1.
- R8: When `ext_req_n` is 0 while the block is idle, `req_ready` is 0 at once. The next cycle has `release_n` at 0 for one cycle, and both enables stay 0 until `ext_req_n` returns to 1. The cycle after that is idle again with enables at 1.
- R9: The address command encoding is bit 8 = 0 (address), bit 7 = 1 for a write and 0 for a read, bits 6..3 = 0, and bits 2..0 = byte count minus one. The byte count `req_size` runs from 1 to 8.
- R10: A read waits only on `rd_rdy_n`, and a write waits only on `wr_rdy_n`. The other ready line has no effect on the address cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 36 | Byte address |
| req_size | input | 4 | Byte count, 1 to 8 |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read data, valid with rsp_valid after a read |
| bus_ad_o | output | 64 | Address/data driven by the block |
| bus_ad_i | input | 64 | Address/data driven by the agent |
| bus_ad_oe | output | 1 | Block drives the address/data path |
| bus_cmd_o | output | 9 | Command driven by the block |
| bus_cmd_i | input | 9 | Command driven by the agent |
| bus_cmd_oe | output | 1 | Block drives the command path |
| valid_out_n | output | 1 | Block drives a valid word, active low |
| valid_in_n | input | 1 | Agent drives a valid word, active low |
| rd_rdy_n | input | 1 | Agent can take a read, active low |
| wr_rdy_n | input | 1 | Agent can take a write, active low |
| ext_req_n | input | 1 | Agent asks for the bus, active low |
| release_n | output | 1 | Block hands the bus over, active low |

## Verification
The bench stretches the ready wait from zero to several cycles. A design that drops or changes the address early then fails the hold checks. The bench drives the ready line of the other type low during every wait, which catches a design that mixes the two lines up. During read waits it offers valid-in words that carry a non-data command, so a design that takes the first valid-in strobe returns the wrong word early. It also runs external requests of different lengths, with the release pulse width and the return to idle checked; a design that keeps release low, or takes the bus back too soon, fails those checks.

// File: rtl/sbrc_pkg.sv
package sbrc_pkg;

    parameter int DATA_W = 64;
    parameter int CMD_W  = 9;
    parameter int ADDR_W = 36;
    parameter int SIZE_W = 4;
    localparam int LANE_W = $clog2(DATA_W / 8);
    localparam int PAD_W  = CMD_W - 2 - LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_REL,
        ST_RDWAIT,
        ST_XREL,
        ST_SLAVE
    } sb_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] wdata;
    } sb_req_t;

    // Address command: [8]=0, [7]=write, middle zero, low bits = count-1
    function automatic logic [CMD_W-1:0] f_addr_cmd(input logic wr,
                                                   input logic [SIZE_W-1:0] sz);
        logic [SIZE_W-1:0] m1;
        m1 = sz - 1'b1;
        return {1'b0, wr, {PAD_W{1'b0}}, m1[LANE_W-1:0]};
    endfunction

    // Data command: [8]=1, [7]=last word, rest zero
    function automatic logic [CMD_W-1:0] f_data_cmd(input logic last);
        return {1'b1, last, {(CMD_W-2){1'b0}}};
    endfunction

    function automatic logic f_is_last_data(input logic [CMD_W-1:0] c);
        return c == f_data_cmd(1'b1);
    endfunction

endpackage

// File: rtl/sbrc_req_latch.sv
module sbrc_req_latch
    import sbrc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sb_req_t req_in,
    output sb_req_t req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (load) begin
            req_q <= req_in;
        end
    end

endmodule

// File: rtl/sbrc_fsm.sv
module sbrc_fsm
    import sbrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      cur_wr,
    input  logic      rd_rdy_n,
    input  logic      wr_rdy_n,
    input  logic      ext_req_n,
    input  logic      valid_in_n,
    input  logic      word_ok,
    output sb_state_e state,
    output logic      accept,
    output logic      rd_take,
    output logic      wr_done
);

    sb_state_e nxt;
    logic      rdy_hit;
    logic      in_read_own;

    assign rdy_hit     = cur_wr ? !wr_rdy_n : !rd_rdy_n;
    assign in_read_own = (state == ST_REL) || (state == ST_RDWAIT);
    assign accept      = (state == ST_IDLE) && ext_req_n && req_valid;
    assign rd_take     = in_read_own && !valid_in_n && word_ok;
    assign wr_done     = (state == ST_WDATA);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!ext_req_n)     nxt = ST_XREL;
                else if (req_valid) nxt = ST_ADDR;
            end
            ST_ADDR: begin
                if (rdy_hit) nxt = cur_wr ? ST_WDATA : ST_REL;
            end
            ST_WDATA: nxt = ST_IDLE;
            ST_REL, ST_RDWAIT: begin
                nxt = rd_take ? ST_IDLE : ST_RDWAIT;
            end
            ST_XREL, ST_SLAVE: begin
                nxt = ext_req_n ? ST_IDLE : ST_SLAVE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/sbrc_bus_drive.sv
module sbrc_bus_drive
    import sbrc_pkg::*;
(
    input  sb_state_e         state,
    input  sb_req_t           req_q,
    output logic [DATA_W-1:0] ad_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              own,
    output logic              vout_n,
    output logic              rel_n
);

    logic in_data;

    assign in_data = (state == ST_WDATA);
    assign ad_o    = in_data ? req_q.wdata
                             : {{(DATA_W-ADDR_W){1'b0}}, req_q.addr};
    assign cmd_o   = in_data ? f_data_cmd(1'b1)
                             : f_addr_cmd(req_q.wr, req_q.size);
    assign own     = !((state == ST_REL) || (state == ST_RDWAIT) ||
                       (state == ST_XREL) || (state == ST_SLAVE));
    assign vout_n  = !((state == ST_ADDR) || in_data);
    assign rel_n   = !((state == ST_REL) || (state == ST_XREL));

endmodule

// File: rtl/sbrc_rsp_capture.sv
module sbrc_rsp_capture
    import sbrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_take,
    input  logic              wr_done,
    input  logic [DATA_W-1:0] ad_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_take || wr_done;
            if (rd_take) rsp_rdata <= ad_i;
        end
    end

endmodule

// File: rtl/sbrc_req_ctrl.sv
module sbrc_req_ctrl
    import sbrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] bus_ad_o,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic              bus_ad_oe,
    output logic [CMD_W-1:0]  bus_cmd_o,
    input  logic [CMD_W-1:0]  bus_cmd_i,
    output logic              bus_cmd_oe,
    output logic              valid_out_n,
    input  logic              valid_in_n,
    input  logic              rd_rdy_n,
    input  logic              wr_rdy_n,
    input  logic              ext_req_n,
    output logic              release_n
);

    sb_state_e state;
    sb_req_t   req_in;
    sb_req_t   req_q;
    logic      accept;
    logic      rd_take;
    logic      wr_done;
    logic      own;

    assign req_in = '{wr: req_write, addr: req_addr, size: req_size, wdata: req_wdata};

    sbrc_req_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .req_in (req_in),
        .req_q  (req_q)
    );

    sbrc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .cur_wr     (req_q.wr),
        .rd_rdy_n   (rd_rdy_n),
        .wr_rdy_n   (wr_rdy_n),
        .ext_req_n  (ext_req_n),
        .valid_in_n (valid_in_n),
        .word_ok    (f_is_last_data(bus_cmd_i)),
        .state      (state),
        .accept     (accept),
        .rd_take    (rd_take),
        .wr_done    (wr_done)
    );

    sbrc_bus_drive u_drive (
        .state  (state),
        .req_q  (req_q),
        .ad_o   (bus_ad_o),
        .cmd_o  (bus_cmd_o),
        .own    (own),
        .vout_n (valid_out_n),
        .rel_n  (release_n)
    );

    sbrc_rsp_capture u_rsp (
        .clk       (clk),
        .rst       (rst),
        .rd_take   (rd_take),
        .wr_done   (wr_done),
        .ad_i      (bus_ad_i),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign bus_ad_oe  = own;
    assign bus_cmd_oe = own;
    assign req_ready  = (state == ST_IDLE) && ext_req_n;

endmodule

// File: rtl/sbrc_req_ctrl_chk.sv
module sbrc_req_ctrl_chk
    import sbrc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] bus_ad_o,
    input logic              bus_ad_oe,
    input logic [CMD_W-1:0]  bus_cmd_o,
    input logic              bus_cmd_oe,
    input logic              valid_out_n,
    input logic              release_n,
    input logic              rd_rdy_n,
    input logic              wr_rdy_n
);

    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        !valid_out_n |-> !req_ready);

    p_valid_driven_r3: assert property (@(posedge clk) disable iff (rst)
        !valid_out_n |-> (bus_ad_oe && bus_cmd_oe));

    p_hold_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (!valid_out_n && !bus_cmd_o[CMD_W-1] && rd_rdy_n && wr_rdy_n)
        |=> (!valid_out_n && $stable(bus_ad_o) && $stable(bus_cmd_o)));

    p_release_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        !release_n |=> release_n);

    p_release_tristate_r8: assert property (@(posedge clk) disable iff (rst)
        !release_n |-> (!bus_ad_oe && !bus_cmd_oe && valid_out_n));

    p_rsp_owned_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (bus_ad_oe && bus_cmd_oe && release_n));

endmodule

bind sbrc_req_ctrl sbrc_req_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe   (bus_ad_oe),
    .bus_cmd_o   (bus_cmd_o),
    .bus_cmd_oe  (bus_cmd_oe),
    .valid_out_n (valid_out_n),
    .release_n   (release_n),
    .rd_rdy_n    (rd_rdy_n),
    .wr_rdy_n    (wr_rdy_n)
);

// File: tb/sim_sbrc_req_ctrl.sv
`timescale 1ns/1ps
module sim_sbrc_req_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [35:0] req_addr = '0;
    logic [3:0]  req_size = 4'd8;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [63:0] bus_ad_o;
    logic [63:0] bus_ad_i = '0;
    logic        bus_ad_oe;
    logic [8:0]  bus_cmd_o;
    logic [8:0]  bus_cmd_i = '0;
    logic        bus_cmd_oe;
    logic        valid_out_n;
    logic        valid_in_n = 1'b1;
    logic        rd_rdy_n = 1'b1;
    logic        wr_rdy_n = 1'b1;
    logic        ext_req_n = 1'b1;
    logic        release_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sbrc_req_ctrl u0 (.*);

    function automatic logic [8:0] exp_addr_cmd(input bit wr, input logic [3:0] sz);
        logic [3:0] m1;
        m1 = sz - 4'd1;
        return {1'b0, wr, 4'b0000, m1[2:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_read(input logic [35:0] a, input logic [3:0] sz,
                           input int rdly, input int ddly, input bit noise,
                           input logic [63:0] d);
        chk(req_ready == 1'b1, "R2 ready before read", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i <= rdly; i++) begin
            chk(valid_out_n == 1'b0 && bus_ad_oe && bus_cmd_oe, "R3 read addr cycle",
                64'({valid_out_n, bus_ad_oe, bus_cmd_oe}), 64'b011);
            chk(bus_ad_o == {28'd0, a}, "R4 read addr held", bus_ad_o, {28'd0, a});
            chk(bus_cmd_o == exp_addr_cmd(1'b0, sz), "R9 read cmd",
                64'(bus_cmd_o), 64'(exp_addr_cmd(1'b0, sz)));
            chk(req_ready == 1'b0, "R2 busy in addr", 64'(req_ready), 64'd0);
            rd_rdy_n = (i == rdly) ? 1'b0 : 1'b1;
            wr_rdy_n = 1'b0; // R10: must not move a read forward
            @(negedge clk);
        end
        rd_rdy_n = 1'b1; wr_rdy_n = 1'b1;
        for (int j = 0; j <= ddly; j++) begin
            chk(!bus_ad_oe && !bus_cmd_oe, "R5 drivers off",
                64'({bus_ad_oe, bus_cmd_oe}), 64'd0);
            chk(release_n == ((j == 0) ? 1'b0 : 1'b1), "R5 release pulse",
                64'(release_n), 64'((j == 0) ? 1'b0 : 1'b1));
            chk(rsp_valid == 1'b0, "R6 no early response", 64'(rsp_valid), 64'd0);
            if (j == ddly) begin
                valid_in_n = 1'b0; bus_cmd_i = 9'h180; bus_ad_i = d;
            end else if (noise) begin
                valid_in_n = 1'b0; bus_cmd_i = 9'h007; bus_ad_i = ~d;
            end else begin
                valid_in_n = 1'b1; bus_cmd_i = 9'h000; bus_ad_i = ~d;
            end
            @(negedge clk);
        end
        valid_in_n = 1'b1; bus_cmd_i = 9'h000; bus_ad_i = '0;
        chk(rsp_valid == 1'b1, "R6 rsp valid", 64'(rsp_valid), 64'd1);
        chk(rsp_rdata == d, "R6 rsp data", rsp_rdata, d);
        chk(bus_ad_oe && release_n, "R6 ownership back",
            64'({bus_ad_oe, release_n}), 64'b11);
        chk(req_ready == 1'b1, "R2 ready after read", 64'(req_ready), 64'd1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R6 rsp one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_write(input logic [35:0] a, input logic [3:0] sz,
                            input int rdly, input logic [63:0] d);
        chk(req_ready == 1'b1, "R2 ready before write", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i <= rdly; i++) begin
            chk(valid_out_n == 1'b0 && bus_ad_oe, "R3 write addr cycle",
                64'({valid_out_n, bus_ad_oe}), 64'b01);
            chk(bus_ad_o == {28'd0, a}, "R4 write addr held", bus_ad_o, {28'd0, a});
            chk(bus_cmd_o == exp_addr_cmd(1'b1, sz), "R9 write cmd",
                64'(bus_cmd_o), 64'(exp_addr_cmd(1'b1, sz)));
            wr_rdy_n = (i == rdly) ? 1'b0 : 1'b1;
            rd_rdy_n = 1'b0; // R10: must not move a write forward
            @(negedge clk);
        end
        wr_rdy_n = 1'b1; rd_rdy_n = 1'b1;
        chk(valid_out_n == 1'b0 && bus_ad_oe, "R7 data cycle valid",
            64'({valid_out_n, bus_ad_oe}), 64'b01);
        chk(bus_ad_o == d, "R7 data word", bus_ad_o, d);
        chk(bus_cmd_o == 9'h180, "R7 data cmd", 64'(bus_cmd_o), 64'h180);
        chk(rsp_valid == 1'b0, "R7 no early done", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b1 && valid_out_n == 1'b1, "R7 write done",
            64'({rsp_valid, valid_out_n}), 64'b11);
        @(negedge clk);
    endtask

    task automatic do_ext(input int hold);
        ext_req_n = 1'b0;
        #1;
        chk(req_ready == 1'b0, "R8 ready drops", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk(release_n == 1'b0 && !bus_ad_oe && !bus_cmd_oe, "R8 release",
            64'({release_n, bus_ad_oe, bus_cmd_oe}), 64'd0);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(release_n == 1'b1 && !bus_ad_oe && valid_out_n, "R8 slave hold",
                64'({release_n, bus_ad_oe, valid_out_n}), 64'b101);
        end
        ext_req_n = 1'b1;
        @(negedge clk);
        chk(bus_ad_oe && bus_cmd_oe && req_ready, "R8 back to idle",
            64'({bus_ad_oe, bus_cmd_oe, req_ready}), 64'b111);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && valid_out_n && release_n && bus_ad_oe && bus_cmd_oe,
            "R1 reset state",
            64'({req_ready, rsp_valid, valid_out_n, release_n, bus_ad_oe, bus_cmd_oe}),
            64'b101111);
        // directed corners
        do_read(36'h0_1234_5675, 4'd1, 0, 0, 1'b0, 64'h0123_4567_89ab_cdef);
        do_read(36'h8_0000_0000, 4'd8, 3, 3, 1'b1, 64'hfeed_0000_beef_1111);
        do_write(36'h0_0000_0003, 4'd3, 0, 64'hdead_beef_0000_0042);
        do_write(36'hf_ffff_fff8, 4'd8, 4, 64'h5555_aaaa_5555_aaaa);
        do_ext(1);
        do_ext(4);
        // random mix
        for (int n = 0; n < 40; n++) begin
            int unsigned kind;
            logic [35:0] a;
            logic [3:0]  sz;
            kind = $urandom % 3;
            a    = {$urandom, $urandom}[35:0];
            sz   = 4'(($urandom % 8) + 1);
            if (kind == 0)
                do_read(a, sz, int'($urandom % 4), int'($urandom % 4),
                        1'($urandom % 2), {$urandom, $urandom});
            else if (kind == 1)
                do_write(a, sz, int'($urandom % 4), {$urandom, $urandom});
            else
                do_ext(int'($urandom % 3) + 1);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule